// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns incoming message-signalled interrupt writes into records in a circular queue that sits in system memory. Each accepted message becomes one 16-byte record. The low 16 bits of the message data word form the interrupt number, which sits in the first bytes of the record, least significant byte first. The rest of the record is zero. The whole record leaves as a single 128-bit memory write. The write lands at the programmable 64-bit base address plus the current write offset.

Software sets the block up through a small word-addressed register port. It uses a control word, two halves of the base address, a read offset that software owns, and a write offset that the hardware advances. A 2-bit size code selects a queue of 32, 64, 128 or 256 KB. Both offsets stay 16-byte aligned and wrap at the selected size.

When advancing the write offset would make it meet the read offset, the queue is full. A control bit then picks what happens:
- Hold the message source off.
- Drop the record and raise a sticky overflow flag.
- Overwrite regardless.

A level interrupt tells the host that records are waiting.

Top module: `msiq_writer`

Both data streams use valid/ready. A message is taken on a cycle where `msi_valid` and `msi_ready` are both high. `msi_ready` is low whenever:
- the block is disabled,
- a record is still waiting for the memory port, or
- the queue is full in stop mode.

Once `mem_valid` is raised, it stays high with address and data unchanged until a cycle where `mem_ready` is high.

## Requirements
- R1: After reset every register reads zero, `irq`, `mem_valid` and `msi_ready` are low.
- R2: Register word addresses are: 0 control, 3 base high, 4 base low, 5 read offset, 6 write offset. Control, base and read offset read back what was written, with masking as in R3. The write offset register ignores writes.
- R3: Control bits 9:8 hold a size code c, and the queue is 2^(15+c) bytes. The offset mask is then the size minus one with bits 3:0 cleared. The read offset reads back as the stored value under the current mask, so writing 0x3FFFF reads 0x7FF0 at c=0, 0xFFF0 at c=1 and 0x3FFF0 at c=3.
- R4: A posted record has `mem_data[15:0]` equal to `msi_data[15:0]` and bits 127:16 zero.
- R5: The record address is {base high, base low} plus the write offset at the time the message is accepted.
- R6: At each memory handshake the write offset advances by 16 under the mask. It wraps from size-16 to 0, and it holds otherwise.
- R7: `msi_ready` is low while control bit 0 (enable) is clear or a record is pending. A pending `mem_valid` keeps its address and data until taken.
- R8: When the queue is full (write offset + 16, masked, equals the read offset) and control bit 4 (stop) is set, `msi_ready` stays low and nothing is written.
- R9: When the queue is full, bit 4 is clear and bit 1 (full detect) is set, a message is accepted and dropped. The write offset is unchanged, and the sticky control bit 2 reads one. Writing control with bit 2 set clears that bit.
- R10: When the queue is full and bits 1 and 4 are both clear, the record is posted and the offset advances as usual.
- R11: `irq` is high exactly when control bit 0 and bit 3 (interrupt enable) are set and the read and write offsets differ.
- R12: Clearing enable while a record is pending does not cancel it. The write completes and the write offset advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| msi_valid | input | 1 | Incoming message present |
| msi_ready | output | 1 | Block accepts the message this cycle |
| msi_data | input | 32 | Message data word |
| mem_valid | output | 1 | Record write request pending |
| mem_ready | input | 1 | Memory takes the record this cycle |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents, byte 0 in bits 7:0 |
| irq | output | 1 | Records waiting interrupt level |

## Verification
The assertions only assume a clean reset. They hold for any pattern on `mem_ready`, because the hold rule is a promise the block makes, not a demand on the memory side. The bench holds `msi_data` steady while `msi_valid` is high and waits for each record to drain before it predicts the next one. It changes the read offset only between records. This way the full/empty prediction is made against a settled write offset. `mem_ready` is drawn at random each cycle, and it is forced low for the in-flight disable case.

// File: rtl/msiq_pkg.sv
`timescale 1ns/1ps
package msiq_pkg;
  localparam int REG_AW = 3;
  localparam int SZ_W   = 2;

  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd4;
  localparam logic [REG_AW-1:0] RA_RD_OFF  = 3'd5;
  localparam logic [REG_AW-1:0] RA_WR_OFF  = 3'd6;

  localparam int CB_EN    = 0;
  localparam int CB_FDET  = 1;
  localparam int CB_OVF   = 2;
  localparam int CB_IRQ   = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_SZ_LO = 8;

  typedef struct packed {
    logic            en;
    logic            fdet;
    logic            irq_en;
    logic            stop;
    logic [SZ_W-1:0] size;
  } ctl_t;
endpackage

// File: rtl/msiq_regs.sv
`timescale 1ns/1ps
module msiq_regs
  import msiq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              set_ovf,
  input  logic [OFF_W-1:0]  mask,
  input  logic [OFF_W-1:0]  roff_m,
  input  logic [OFF_W-1:0]  woff_m,
  output ctl_t              ctl,
  output logic [2*DW-1:0]   base,
  output logic [OFF_W-1:0]  roff_q
);
  logic          ovf_q;
  logic [DW-1:0] base_hi_q, base_lo_q;
  logic          wr_ctl;

  assign wr_ctl = reg_we && (reg_addr == RA_CTRL);
  assign base   = {base_hi_q, base_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      roff_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL: begin
          ctl.en     <= reg_wdata[CB_EN];
          ctl.fdet   <= reg_wdata[CB_FDET];
          ctl.irq_en <= reg_wdata[CB_IRQ];
          ctl.stop   <= reg_wdata[CB_STOP];
          ctl.size   <= reg_wdata[CB_SZ_LO +: SZ_W];
        end
        RA_BASE_HI: base_hi_q <= reg_wdata;
        RA_BASE_LO: base_lo_q <= reg_wdata;
        RA_RD_OFF:  roff_q    <= reg_wdata[OFF_W-1:0] & mask;
        default: ;
      endcase
    end
  end

  // sticky overflow: a drop in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovf_q <= 1'b0;
    else if (set_ovf)                   ovf_q <= 1'b1;
    else if (wr_ctl && reg_wdata[CB_OVF]) ovf_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_EN]              = ctl.en;
        reg_rdata[CB_FDET]            = ctl.fdet;
        reg_rdata[CB_OVF]             = ovf_q;
        reg_rdata[CB_IRQ]             = ctl.irq_en;
        reg_rdata[CB_STOP]            = ctl.stop;
        reg_rdata[CB_SZ_LO +: SZ_W]   = ctl.size;
      end
      RA_BASE_HI: reg_rdata = base_hi_q;
      RA_BASE_LO: reg_rdata = base_lo_q;
      RA_RD_OFF:  reg_rdata = {{(DW-OFF_W){1'b0}}, roff_m};
      RA_WR_OFF:  reg_rdata = {{(DW-OFF_W){1'b0}}, woff_m};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msiq_ptr.sv
`timescale 1ns/1ps
module msiq_ptr
  import msiq_pkg::*;
#(
  parameter int OFF_W     = 18,
  parameter int REC_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SZ_W-1:0]  size,
  input  logic [OFF_W-1:0] roff_q,
  input  logic             adv,
  output logic [OFF_W-1:0] mask,
  output logic [OFF_W-1:0] roff_m,
  output logic [OFF_W-1:0] woff_m,
  output logic [OFF_W-1:0] woff_q,
  output logic             full,
  output logic             empty
);
  localparam logic [SZ_W-1:0]  SZ_MAX  = SZ_W'((1 << SZ_W) - 1);
  localparam logic [OFF_W-1:0] REC     = OFF_W'(REC_BYTES);
  localparam logic [OFF_W-1:0] REC_LOW = OFF_W'(REC_BYTES - 1);

  logic [OFF_W-1:0] woff_next;

  assign mask      = ({OFF_W{1'b1}} >> (SZ_MAX - size)) & ~REC_LOW;
  assign roff_m    = roff_q & mask;
  assign woff_m    = woff_q & mask;
  assign woff_next = (woff_m + REC) & mask;
  assign full      = (woff_next == roff_m);
  assign empty     = (woff_m == roff_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   woff_q <= '0;
    else if (adv) woff_q <= woff_next;
  end
endmodule

// File: rtl/msiq_writer.sv
`timescale 1ns/1ps
module msiq_writer
  import msiq_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int MEM_W     = 128,
  parameter int MIN_SHIFT = 15,
  parameter int REC_BYTES = 16,
  parameter int IRQ_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 msi_valid,
  output logic                 msi_ready,
  input  logic [REG_W-1:0]     msi_data,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [2*REG_W-1:0]   mem_addr,
  output logic [MEM_W-1:0]     mem_data,
  output logic                 irq
);
  localparam int ADDR_W = 2 * REG_W;
  localparam int OFF_W  = MIN_SHIFT + (1 << SZ_W) - 1;

  ctl_t              ctl;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  roff_q, roff_m, woff_m, woff_q, mask;
  logic              full, empty, accept, drop, post, adv;

  msiq_regs #(.DW(REG_W), .OFF_W(OFF_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_ovf(drop), .mask(mask), .roff_m(roff_m), .woff_m(woff_m),
    .ctl(ctl), .base(base), .roff_q(roff_q)
  );

  msiq_ptr #(.OFF_W(OFF_W), .REC_BYTES(REC_BYTES)) ptr_i (
    .clk(clk), .rst_n(rst_n), .size(ctl.size), .roff_q(roff_q), .adv(adv),
    .mask(mask), .roff_m(roff_m), .woff_m(woff_m), .woff_q(woff_q),
    .full(full), .empty(empty)
  );

  assign msi_ready = ctl.en && !mem_valid && !(full && ctl.stop);
  assign accept    = msi_valid && msi_ready;
  assign drop      = accept && full && ctl.fdet;
  assign post      = accept && !drop;
  assign adv       = mem_valid && mem_ready;
  assign irq       = ctl.en && ctl.irq_en && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (post) begin
      mem_valid <= 1'b1;
      mem_addr  <= base + {{(ADDR_W-OFF_W){1'b0}}, woff_m};
      mem_data  <= {{(MEM_W-IRQ_W){1'b0}}, msi_data[IRQ_W-1:0]};
    end else if (adv) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msiq_writer_chk.sv
`timescale 1ns/1ps
module msiq_writer_chk #(
  parameter int OFF_W  = 18,
  parameter int ADDR_W = 64,
  parameter int MEM_W  = 128,
  parameter int IRQ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [MEM_W-1:0]  mem_data,
  input logic              irq,
  input logic              en,
  input logic              irq_en,
  input logic              stop,
  input logic              full,
  input logic [OFF_W-1:0]  woff_q,
  input logic [OFF_W-1:0]  woff_m
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R7
  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !msi_ready); // R7
  AST_REC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_data[MEM_W-1:IRQ_W] == '0); // R4
  AST_WOFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    woff_m[3:0] == 4'd0); // R3
  AST_WOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready) |=> $stable(woff_q)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && irq_en) |-> !irq); // R11
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && stop && full |-> !msi_ready); // R8
endmodule

bind msiq_writer msiq_writer_chk #(
  .OFF_W(OFF_W), .ADDR_W(ADDR_W), .MEM_W(MEM_W), .IRQ_W(IRQ_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .msi_ready(msi_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
  .en(ctl.en), .irq_en(ctl.irq_en), .stop(ctl.stop), .full(full),
  .woff_q(woff_q), .woff_m(woff_m)
);

// File: tb/msiq_writer_tb.sv
`timescale 1ns/1ps
module msiq_writer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic         msi_ready;
  logic [31:0]  msi_data = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  int tests = 0, fails = 0, cap_cnt = 0;
  bit stall_en = 1'b1, hold_mem = 1'b0;
  logic [63:0]  cap_addr, exp_base = '0;
  logic [127:0] cap_data;
  logic [17:0]  exp_woff = '0, exp_roff = '0;
  logic [31:0]  cur_ctl = '0;

  msiq_writer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_ready(msi_ready), .msi_data(msi_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  always #2 clk = ~clk;

  // memory side: pick ready at negedge, log the handshake due at the next posedge
  always @(negedge clk) begin
    mem_ready = hold_mem ? 1'b0 : (stall_en ? 1'($urandom % 2) : 1'b1);
    if (mem_valid && mem_ready) begin
      cap_addr = mem_addr;
      cap_data = mem_data;
      cap_cnt++;
    end
  end

  function automatic logic [17:0] msk(logic [1:0] c);
    return (18'h3FFFF >> (2'd3 - c)) & ~18'hF;
  endfunction

  function automatic logic is_full();
    return ((exp_woff + 18'd16) & msk(cur_ctl[9:8])) == exp_roff;
  endfunction

  // 0 post, 1 drop, 2 held off
  function automatic int predict(logic [31:0] ctl, logic fl);
    if (!fl)    return 0;
    if (ctl[4]) return 2;
    if (ctl[1]) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: cur_ctl = d & ~32'h4;
      3'd3: exp_base[63:32] = d;
      3'd4: exp_base[31:0] = d;
      3'd5: exp_roff = d[17:0] & msk(cur_ctl[9:8]);
      default: ;
    endcase
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic handshake_in();
    while (!msi_ready) @(negedge clk);
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic finish_post(input logic [31:0] d, input int n0);
    logic [31:0] v;
    while (cap_cnt == n0) @(negedge clk);
    @(negedge clk);
    chk(cap_addr == exp_base + {46'd0, exp_woff}, "R5 record address", cap_addr, exp_base + {46'd0, exp_woff});
    chk(cap_data == {112'd0, d[15:0]}, "R4 record contents", cap_data, {112'd0, d[15:0]});
    exp_woff = (exp_woff + 18'd16) & msk(cur_ctl[9:8]);
    rreg(3'd6, v);
    chk(v == {14'd0, exp_woff}, "R6 write offset advance", v, {14'd0, exp_woff});
  endtask

  task automatic send(input logic [31:0] d);
    int oc, n0;
    logic [31:0] v;
    oc = predict(cur_ctl, is_full());
    n0 = cap_cnt;
    msi_valid = 1'b1; msi_data = d;
    handshake_in();
    if (oc == 0) finish_post(d, n0);
    else begin
      repeat (3) @(negedge clk);
      chk(cap_cnt == n0, "R9 dropped record not written", 128'(cap_cnt), 128'(n0));
      rreg(3'd6, v);
      chk(v == {14'd0, exp_woff}, "R9 write offset unchanged", v, {14'd0, exp_woff});
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [17:0] m;
    int n0;
    bit wrapped;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(!irq && !mem_valid && !msi_ready, "R1 outputs after reset", {irq, mem_valid, msi_ready}, 0);

    // R2 register map
    wreg(3'd3, 32'h0000_0001);
    wreg(3'd4, 32'h8000_0000);
    rreg(3'd3, v); chk(v == 32'h1, "R2 base high readback", v, 32'h1);
    rreg(3'd4, v); chk(v == 32'h8000_0000, "R2 base low readback", v, 32'h8000_0000);
    wreg(3'd6, 32'h100);
    rreg(3'd6, v); chk(v == 0, "R2 write offset ignores writes", v, 0);
    wreg(3'd0, 32'h0000_0009);
    rreg(3'd0, v); chk(v == 32'h9, "R2 control readback", v, 32'h9);
    chk(irq == 0, "R11 irq low when empty", irq, 0);

    // first record
    send(32'hABCD_1234);
    chk(irq == 1, "R11 irq high when offsets differ", irq, 1);

    // R3 masking of the read offset
    wreg(3'd5, 32'h3FFFF);
    rreg(3'd5, v); chk(v == 32'h7FF0, "R3 read offset mask size 0", v, 32'h7FF0);
    wreg(3'd5, {14'd0, exp_woff});
    chk(irq == 0, "R11 irq low after consume", irq, 0);

    // random stream, wraps the 32 KB queue
    wrapped = 1'b0;
    for (int i = 0; i < 2100; i++) begin
      send($urandom);
      if (exp_woff == 0) wrapped = 1'b1;
      if ($urandom % 2) wreg(3'd5, {14'd0, exp_woff});
    end
    chk(wrapped, "R6 write offset wrapped to zero", wrapped, 1);

    // R8 full with stop
    m = msk(cur_ctl[9:8]);
    wreg(3'd0, 32'h19);
    wreg(3'd5, {14'd0, (exp_woff + 18'd16) & m});
    n0 = cap_cnt;
    msi_valid = 1'b1; msi_data = 32'h0000_5555;
    repeat (4) @(negedge clk);
    chk(msi_ready == 0, "R8 ready low when full and stop", msi_ready, 0);
    chk(cap_cnt == n0, "R8 nothing written when held", 128'(cap_cnt), 128'(n0));
    wreg(3'd5, {14'd0, exp_woff});
    handshake_in();
    finish_post(32'h0000_5555, n0);

    // R9 full with detect: drop and sticky flag
    wreg(3'd0, 32'h0B);
    wreg(3'd5, {14'd0, (exp_woff + 18'd16) & m});
    send(32'h0000_7777);
    rreg(3'd0, v); chk(v == 32'h0F, "R9 sticky overflow set", v, 32'h0F);
    wreg(3'd0, 32'h0F);
    rreg(3'd0, v); chk(v == 32'h0B, "R9 overflow cleared by write", v, 32'h0B);

    // R10 full without detect or stop: overwrite
    wreg(3'd0, 32'h09);
    n0 = cap_cnt;
    send(32'h0000_2222);
    chk(cap_cnt == n0 + 1, "R10 record posted when full", 128'(cap_cnt), 128'(n0 + 1));
    chk(irq == 0, "R11 irq low once offsets meet", irq, 0);

    // R12 disable with a record in flight
    wreg(3'd5, {14'd0, (exp_woff + 18'd32) & m});
    chk(irq == 1, "R11 irq high nonempty", irq, 1);
    hold_mem = 1'b1;
    n0 = cap_cnt;
    msi_valid = 1'b1; msi_data = 32'h0000_3333;
    handshake_in();
    wreg(3'd0, 32'h08);
    chk(mem_valid == 1, "R12 pending record kept after disable", mem_valid, 1);
    chk(irq == 0, "R11 irq low when disabled", irq, 0);
    msi_valid = 1'b1; msi_data = 32'h0000_4444;
    repeat (3) @(negedge clk);
    chk(msi_ready == 0, "R7 ready low while disabled", msi_ready, 0);
    msi_valid = 1'b0;
    hold_mem = 1'b0;
    finish_post(32'h0000_3333, n0);
    repeat (3) @(negedge clk);
    chk(cap_cnt == n0 + 1, "R7 no record taken while disabled", 128'(cap_cnt), 128'(n0 + 1));

    // R3 other size codes
    wreg(3'd0, 32'h301);
    wreg(3'd5, 32'h3FFFF);
    rreg(3'd5, v); chk(v == 32'h3FFF0, "R3 read offset mask size 3", v, 32'h3FFF0);
    wreg(3'd0, 32'h101);
    rreg(3'd5, v); chk(v == 32'hFFF0, "R3 read offset mask size 1", v, 32'hFFF0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule